// File: doc/BRIEF.md
# I2C Controller Command and Control Register

This block is the 16-bit control register that sits between a CPU bus and an I2C controller core. The CPU writes it to enable the controller, choose master operation and the operating mode, and control acknowledge generation and clock stretching. It also uses it to request START and STOP conditions and to reset the controller. The register sends every field to the core as a separate output. It takes back four status events from the core (reset complete, START generated, STOP generated, timeout) and one level (busy).

The block is not plain storage. The START and STOP requests clear themselves, and at most one of them can be pending at a time. Some fields refuse writes while the core is busy or while a controller reset is pending. Both commands and the reset request are withdrawn by hardware when the controller is disabled or leaves master mode. Each write is judged against the register contents as they were before that write. The new contents appear on the outputs on the clock edge that samples the write strobe.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset, every field and `rdata` are 0.
- R2: While `rd_en` is 1, `rdata` shows the register. Bit 15 is reset request, bit 9 stretch enable, bit 8 general-call enable, bit 7 STOP, bit 6 START, bit 5 ACK, bit 4 stretch point, bit 2 mode, bit 1 master and bit 0 enable. Bits 14..10 and bit 3 read 0. While `rd_en` is 0, `rdata` is 0.
- R3: Stretch enable, general-call enable and stretch point take the written value on every write.
- R4: Writing 1 to bit 15 sets the reset request, and writing 0 to it has no effect. The request clears on `core_reset_done`, and also whenever enable (after the current write) is 0.
- R5: `core_start_done` clears START, `core_stop_done` clears STOP, and `core_timeout` clears both. A clear beats a set request in the same cycle.
- R6: A write with bits 7 and 6 both 1 leaves both START and STOP at 0.
- R7: While `core_busy` is 1, writes to master and mode are ignored. Enable is also ignored, unless the reset request is 1.
- R8: While the reset request is 1, writes to ACK are ignored.
- R9: Writing START while STOP is 1 is ignored, and the reverse is also ignored. Writing 0 to either command bit has no effect.
- R10: START and STOP are 0 whenever master or enable (after the current write) is 0.
- R11: A write is judged against the state before it. A single write that sets the reset request also updates ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wdata | input | 16 | CPU write data |
| rd_en | input | 1 | CPU read strobe |
| rdata | output | 16 | Register image, 0 when not read |
| core_busy | input | 1 | Core is busy |
| core_reset_done | input | 1 | Controller reset finished |
| core_start_done | input | 1 | START condition generated |
| core_stop_done | input | 1 | STOP condition generated |
| core_timeout | input | 1 | Timeout event |
| ctl_reset | output | 1 | Controller reset request |
| ctl_stretch_en | output | 1 | Clock stretch enable |
| ctl_gcall_en | output | 1 | General-call response enable |
| ctl_stop_req | output | 1 | STOP request |
| ctl_start_req | output | 1 | START request |
| ctl_ack | output | 1 | ACK control |
| ctl_stretch_sel | output | 1 | Stretch point select |
| ctl_mode | output | 1 | Mode select |
| ctl_master | output | 1 | Master select |
| ctl_enable | output | 1 | Controller enable |

## Verification
The bench writes all ones to check both invalid command cases at once. It expects START and STOP both 0; a design that let one command win would show it pending. It writes while busy with the reset request set, and expects enable to drop while master and mode hold. Three wrong designs fail here: one that locks every field, one that accepts every field, and one that keeps the reset request after disable. It also checks that a single write can both set the reset request and change ACK. A design that judged the ACK lock against the new value would drop that ACK update.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
   localparam int unsigned CTL_W    = 16;
   localparam int unsigned B_RST    = 15;
   localparam int unsigned B_STREN  = 9;
   localparam int unsigned B_GCEN   = 8;
   localparam int unsigned B_STOP   = 7;
   localparam int unsigned B_START  = 6;
   localparam int unsigned B_ACK    = 5;
   localparam int unsigned B_STRS   = 4;
   localparam int unsigned B_MODE   = 2;
   localparam int unsigned B_MST    = 1;
   localparam int unsigned B_EN     = 0;
   localparam int unsigned N_PLAIN  = 3;
   localparam int unsigned N_GATED  = 4;
endpackage

// File: rtl/i2c_ctl_bitreg.sv
module i2c_ctl_bitreg #(
   parameter int unsigned N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ld,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (N < 1) begin : g_bad
      $error("i2c_ctl_bitreg: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= 1'b0;
         else if (ld[i]) q[i] <= d[i];
      end
   end
endmodule

// File: rtl/i2c_ctl_accept.sv
module i2c_ctl_accept (
   input  logic wr_en,
   input  logic busy,
   input  logic rst_pend,
   output logic acc_core,
   output logic acc_en,
   output logic acc_ack
);
   always_comb begin
      acc_core = wr_en & ~busy;
      acc_en   = wr_en & (~busy | rst_pend);
      acc_ack  = wr_en & ~rst_pend;
   end
endmodule

// File: rtl/i2c_ctl_cmd.sv
module i2c_ctl_cmd (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic w_start,
   input  logic w_stop,
   input  logic allow,
   input  logic start_done,
   input  logic stop_done,
   input  logic timeout,
   output logic start_q,
   output logic stop_q
);
   logic both_w, set_start, set_stop, clr_start, clr_stop;
   logic start_nx, stop_nx;

   always_comb begin
      both_w    = wr_en & w_start & w_stop;
      set_start = wr_en & w_start & ~w_stop & ~stop_q;
      set_stop  = wr_en & w_stop & ~w_start & ~start_q;
      clr_start = start_done | timeout | both_w | ~allow;
      clr_stop  = stop_done | timeout | both_w | ~allow;
      start_nx  = start_q;
      stop_nx   = stop_q;
      if (clr_start)      start_nx = 1'b0;
      else if (set_start) start_nx = 1'b1;
      if (clr_stop)       stop_nx  = 1'b0;
      else if (set_stop)  stop_nx  = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         stop_q  <= 1'b0;
      end else begin
         start_q <= start_nx;
         stop_q  <= stop_nx;
      end
   end
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
   import i2c_ctl_pkg::*;
#(
   parameter int unsigned REG_W  = CTL_W,
   parameter bit          RD_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             rd_en,
   output logic [REG_W-1:0] rdata,
   input  logic             core_busy,
   input  logic             core_reset_done,
   input  logic             core_start_done,
   input  logic             core_stop_done,
   input  logic             core_timeout,
   output logic             ctl_reset,
   output logic             ctl_stretch_en,
   output logic             ctl_gcall_en,
   output logic             ctl_stop_req,
   output logic             ctl_start_req,
   output logic             ctl_ack,
   output logic             ctl_stretch_sel,
   output logic             ctl_mode,
   output logic             ctl_master,
   output logic             ctl_enable
);
   if (REG_W != CTL_W) begin : g_bad_width
      $error("i2c_ctl_reg: REG_W must be 16");
   end

   logic acc_core, acc_en, acc_ack;
   logic en_nx, mst_nx, rst_q;
   logic [N_PLAIN-1:0] plain_q;
   logic [N_GATED-1:0] gated_q, gated_ld, gated_d;
   logic [REG_W-1:0]   img;

   i2c_ctl_accept u_acc (
      .wr_en    (wr_en),
      .busy     (core_busy),
      .rst_pend (rst_q),
      .acc_core (acc_core),
      .acc_en   (acc_en),
      .acc_ack  (acc_ack)
   );

   // order in gated vector: ack, mode, master, enable
   assign gated_ld = {acc_ack, acc_core, acc_core, acc_en};
   assign gated_d  = {wdata[B_ACK], wdata[B_MODE], wdata[B_MST], wdata[B_EN]};

   i2c_ctl_bitreg #(.N(N_GATED)) u_gated (
      .clk (clk), .rst_n (rst_n), .ld (gated_ld), .d (gated_d), .q (gated_q)
   );

   i2c_ctl_bitreg #(.N(N_PLAIN)) u_plain (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    ({N_PLAIN{wr_en}}),
      .d     ({wdata[B_STREN], wdata[B_GCEN], wdata[B_STRS]}),
      .q     (plain_q)
   );

   assign en_nx  = acc_en   ? wdata[B_EN]  : gated_q[0];
   assign mst_nx = acc_core ? wdata[B_MST] : gated_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rst_q <= 1'b0;
      else if (!en_nx)                 rst_q <= 1'b0;
      else if (core_reset_done)        rst_q <= 1'b0;
      else if (wr_en && wdata[B_RST])  rst_q <= 1'b1;
   end

   i2c_ctl_cmd u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .w_start    (wdata[B_START]),
      .w_stop     (wdata[B_STOP]),
      .allow      (en_nx & mst_nx),
      .start_done (core_start_done),
      .stop_done  (core_stop_done),
      .timeout    (core_timeout),
      .start_q    (ctl_start_req),
      .stop_q     (ctl_stop_req)
   );

   assign ctl_reset       = rst_q;
   assign ctl_stretch_en  = plain_q[2];
   assign ctl_gcall_en    = plain_q[1];
   assign ctl_stretch_sel = plain_q[0];
   assign ctl_ack         = gated_q[3];
   assign ctl_mode        = gated_q[2];
   assign ctl_master      = gated_q[1];
   assign ctl_enable      = gated_q[0];

   always_comb begin
      img          = '0;
      img[B_RST]   = rst_q;
      img[B_STREN] = ctl_stretch_en;
      img[B_GCEN]  = ctl_gcall_en;
      img[B_STOP]  = ctl_stop_req;
      img[B_START] = ctl_start_req;
      img[B_ACK]   = ctl_ack;
      img[B_STRS]  = ctl_stretch_sel;
      img[B_MODE]  = ctl_mode;
      img[B_MST]   = ctl_master;
      img[B_EN]    = ctl_enable;
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_en ? img : '0;
      end
   end else begin : g_rd_comb
      assign rdata = rd_en ? img : '0;
   end
endmodule

// File: rtl/i2c_ctl_reg_chk.sv
module i2c_ctl_reg_chk (
   input logic clk,
   input logic rst_n,
   input logic core_busy,
   input logic core_reset_done,
   input logic core_start_done,
   input logic core_stop_done,
   input logic ctl_reset,
   input logic ctl_start_req,
   input logic ctl_stop_req,
   input logic ctl_ack,
   input logic ctl_mode,
   input logic ctl_master,
   input logic ctl_enable
);
   a_r10_cmd_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_enable || !ctl_master) |-> (!ctl_start_req && !ctl_stop_req));
   a_r9_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_start_req && ctl_stop_req));
   a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      core_reset_done |=> !ctl_reset);
   a_r4_off_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_enable |-> !ctl_reset);
   a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      core_start_done |=> !ctl_start_req);
   a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      core_stop_done |=> !ctl_stop_req);
   a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      core_busy |=> ($stable(ctl_master) && $stable(ctl_mode)));
   a_r7_busy_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (core_busy && !ctl_reset) |=> $stable(ctl_enable));
   a_r8_ack_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_reset |=> $stable(ctl_ack));
endmodule

bind i2c_ctl_reg i2c_ctl_reg_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .core_busy       (core_busy),
   .core_reset_done (core_reset_done),
   .core_start_done (core_start_done),
   .core_stop_done  (core_stop_done),
   .ctl_reset       (ctl_reset),
   .ctl_start_req   (ctl_start_req),
   .ctl_stop_req    (ctl_stop_req),
   .ctl_ack         (ctl_ack),
   .ctl_mode        (ctl_mode),
   .ctl_master      (ctl_master),
   .ctl_enable      (ctl_enable)
);

// File: tb/tb_i2c_ctl_reg.sv
`timescale 1ns/1ps
module tb_i2c_ctl_reg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic core_busy = 1'b0, core_reset_done = 1'b0, core_start_done = 1'b0;
   logic core_stop_done = 1'b0, core_timeout = 1'b0;
   logic ctl_reset, ctl_stretch_en, ctl_gcall_en, ctl_stop_req, ctl_start_req;
   logic ctl_ack, ctl_stretch_sel, ctl_mode, ctl_master, ctl_enable;

   int total = 0;
   int bad = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   i2c_ctl_reg dut (.*);

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] exp, input string tag);
      @(posedge clk); #1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(posedge clk); #1;
      case (which)
         0: core_reset_done = 1'b1;
         1: core_start_done = 1'b1;
         2: core_stop_done  = 1'b1;
         default: core_timeout = 1'b1;
      endcase
      @(posedge clk); #1;
      core_reset_done = 1'b0; core_start_done = 1'b0;
      core_stop_done = 1'b0;  core_timeout = 1'b0;
   endtask

   // monitor: pops one expected item per read strobe
   always @(negedge clk) begin
      if (rd_en) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%h expected=none", rdata);
         end else begin
            check(rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      rd(16'h0000, "R1 reset state");
      wr(16'hFFFF);
      rd(16'h8337, "R2 R3 R6 all-ones write, reserved zero, both commands dropped");
      @(negedge clk);
      check({15'd0, ctl_stretch_en}, 16'd1, "R3 stretch enable port");
      pulse(0);
      rd(16'h0337, "R4 reset done clears request");
      wr(16'h8007);
      rd(16'h8007, "R4 set reset request");
      wr(16'h0027);
      rd(16'h8007, "R8 ack ignored under reset, R4 write 0 keeps request");
      core_busy = 1'b1;
      wr(16'h0000);
      rd(16'h0006, "R7 enable accepted under reset while busy, R4 cleared by disable");
      wr(16'h0007);
      rd(16'h0006, "R7 enable locked while busy");
      core_busy = 1'b0;
      wr(16'h0007);
      wr(16'h0047);
      rd(16'h0047, "R5 start set");
      wr(16'h00C7);
      rd(16'h0007, "R6 start and stop together");
      wr(16'h0047);
      wr(16'h0087);
      rd(16'h0047, "R9 stop ignored while start pending");
      pulse(1);
      rd(16'h0007, "R5 start done clears");
      wr(16'h0087);
      wr(16'h0047);
      rd(16'h0087, "R9 start ignored while stop pending");
      pulse(2);
      rd(16'h0007, "R5 stop done clears");
      wr(16'h0047);
      pulse(3);
      rd(16'h0007, "R5 timeout clears");
      wr(16'h0087);
      wr(16'h0005);
      rd(16'h0005, "R10 leaving master drops stop");
      wr(16'h0045);
      rd(16'h0005, "R10 start refused in slave mode");
      wr(16'h0047);
      wr(16'h0006);
      rd(16'h0006, "R10 disable drops start");
      wr(16'h0000);
      wr(16'h8027);
      rd(16'h8027, "R11 ack judged against old reset request");
      @(negedge clk);
      check(rdata, 16'h0000, "R2 no read strobe");
      repeat (3) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule